// File: doc/BRIEF.md
# Horizontally Microcoded Accumulator Processor

This block is a small accumulator computer built around one shared data bus. Its datapath holds a program counter, a memory address register, an ALU operand register, an accumulator and a 256-word, 8-bit memory. A constant-zero source can also drive the bus. The control unit has no instruction register. A 32-word horizontal microcode store drives the datapath. Each microword carries twelve strobes, a sequencing mode, a source select and a 5-bit target microaddress.

Every microcycle the sequencer does one of three things. It steps to the next microaddress, it jumps unconditionally, or it jumps only when the accumulator is zero. A jump takes its target either from the microword or from the low three bits of the word on the bus. That second source is how the shared fetch routine dispatches into an eight-entry jump table at microaddresses 0 to 7. Each entry of the table forwards to the routine for one instruction.

Instructions that use memory are two words long: an opcode word, then an operand word that holds a memory address. The no-op, clear and halt instructions are one word long. A program is preloaded through a write port while reset is held. Results are observed through a read port and through the PC, accumulator, microaddress and halted outputs.

Top module: `mc_accum_cpu`

## Requirements
- R1: While reset is low, the microaddress, PC and accumulator read 0 and halted reads 0. The first clock edge after reset is released moves the microaddress from 0 to 8.
- R2: Fetch takes microaddress 8 and then 9. After 9 comes the dispatch entry given by the low three bits of the opcode word (upper bits are ignored, so 0x0A behaves as opcode 2). Then comes that opcode's routine, which returns to 8. No more than one bus source is enabled in any microcycle.
- R3: Opcode 1 (load) sets the accumulator to mem[operand]. Its microaddresses are 8, 9, 1, 10, 11, 12, 13.
- R4: Opcode 2 (add) sets the accumulator to acc + mem[operand] modulo 256. Its microaddresses are 8, 9, 2, 14 to 17.
- R5: Opcode 3 (subtract) sets the accumulator to acc - mem[operand] modulo 256. Its microaddresses are 8, 9, 3, 18 to 21.
- R6: Opcode 4 (store) writes the accumulator to mem[operand]. Its microaddresses are 8, 9, 4, 22, 23, 24.
- R7: Opcode 5 (jump if zero) always consumes its operand. When the accumulator is zero, the PC becomes the operand and the microaddresses are 8, 9, 5, 25, 26, 28. Otherwise the PC points past the operand and the microaddresses are 8, 9, 5, 25, 26, 27.
- R8: Opcode 6 (clear) is one word long and sets the accumulator to 0. Its microaddresses are 8, 9, 6, 29, 30.
- R9: Opcode 7 (halt) is one word long and reaches microaddress 31. Halted reads 1 one cycle after 31 is entered. From then until reset, the microaddress stays at 31 and the PC, accumulator and memory do not change.
- R10: Opcode 0 is a one-word no-op. Its microaddresses are 8, 9, 0, and it changes nothing except that the PC advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Preload write strobe for memory |
| loadAddr | input | DATA_W | Preload write address |
| loadData | input | DATA_W | Preload write data |
| peekAddr | input | DATA_W | Memory read-back address |
| peekData | output | DATA_W | Memory word at peekAddr, combinational |
| pcOut | output | DATA_W | Program counter |
| accOut | output | DATA_W | Accumulator |
| uAddr | output | 5 | Current microaddress |
| halted | output | 1 | Processor stopped |

## Verification
The microaddress is registered, so the entry for a microcycle is visible for the whole cycle after the edge that selected it. The bench compares it against its queue at every falling edge. Register results land on the edge that ends the routine's last microword, so the PC and accumulator are compared each time microaddress 8 is observed, which is one cycle after that edge. Halted rises one edge after microaddress 31 appears. The bench therefore expects 0 on the first cycle at 31 and 1 on every cycle after it. Memory is read back through the combinational port once the program has stopped, and also checked against hand-computed stored values.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int UA_W = 5;
  localparam int OP_W = 3;
  localparam int DISPATCH_N = 1 << OP_W;

  // named microcode entry points
  localparam logic [UA_W-1:0] UA_FETCH    = 5'd8;
  localparam logic [UA_W-1:0] UA_LOAD     = 5'd10;
  localparam logic [UA_W-1:0] UA_ADD      = 5'd14;
  localparam logic [UA_W-1:0] UA_SUB      = 5'd18;
  localparam logic [UA_W-1:0] UA_STORE    = 5'd22;
  localparam logic [UA_W-1:0] UA_JZ       = 5'd25;
  localparam logic [UA_W-1:0] UA_JZ_TAKEN = 5'd28;
  localparam logic [UA_W-1:0] UA_CLEAR    = 5'd29;
  localparam logic [UA_W-1:0] UA_STOP     = 5'd31;

  typedef struct packed {
    logic pcOe;
    logic constOe;
    logic accOe;
    logic memOe;
    logic pcInc;
    logic pcLd;
    logic accLd;
    logic abrLd;
    logic aluSub;
    logic marLd;
    logic memWe;
    logic stop;
  } strobe_t;

  typedef enum logic [1:0] {
    SEQ_STEP   = 2'd0,
    SEQ_JUMP   = 2'd1,
    SEQ_IFZERO = 2'd2
  } seq_e;

  typedef struct packed {
    seq_e            seq;
    logic            fromBus;
    logic [UA_W-1:0] target;
    strobe_t         ctl;
  } uword_t;

endpackage

// File: rtl/mc_urom.sv
module mc_urom
  import mc_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);

  function automatic uword_t goTo(input logic [UA_W-1:0] t);
    uword_t w;
    w = '0;
    w.seq = SEQ_JUMP;
    w.target = t;
    return w;
  endfunction

  function automatic logic [UA_W-1:0] entryOf(input logic [OP_W-1:0] op);
    logic [UA_W-1:0] t;
    case (op)
      3'd1:    t = UA_LOAD;
      3'd2:    t = UA_ADD;
      3'd3:    t = UA_SUB;
      3'd4:    t = UA_STORE;
      3'd5:    t = UA_JZ;
      3'd6:    t = UA_CLEAR;
      3'd7:    t = UA_STOP;
      default: t = UA_FETCH;
    endcase
    return t;
  endfunction

  always_comb begin
    word = '0;
    if (addr < UA_W'(DISPATCH_N)) begin
      word = goTo(entryOf(addr[OP_W-1:0]));
    end else begin
      case (addr)
        5'd8: begin
          word.ctl.pcOe  = 1'b1;
          word.ctl.marLd = 1'b1;
        end
        5'd9: begin
          word.ctl.pcInc = 1'b1;
          word.ctl.memOe = 1'b1;
          word.seq       = SEQ_JUMP;
          word.fromBus   = 1'b1;
        end
        5'd10, 5'd29: begin
          word.ctl.constOe = 1'b1;
          word.ctl.abrLd   = 1'b1;
        end
        5'd11, 5'd15, 5'd19, 5'd22, 5'd25: begin
          word.ctl.pcOe  = 1'b1;
          word.ctl.pcInc = 1'b1;
          word.ctl.marLd = 1'b1;
        end
        5'd12, 5'd16, 5'd20, 5'd23: begin
          word.ctl.memOe = 1'b1;
          word.ctl.marLd = 1'b1;
        end
        5'd13, 5'd17: begin
          word = goTo(UA_FETCH);
          word.ctl.memOe = 1'b1;
          word.ctl.accLd = 1'b1;
        end
        5'd21: begin
          word = goTo(UA_FETCH);
          word.ctl.memOe  = 1'b1;
          word.ctl.accLd  = 1'b1;
          word.ctl.aluSub = 1'b1;
        end
        5'd14, 5'd18: begin
          word.ctl.accOe = 1'b1;
          word.ctl.abrLd = 1'b1;
        end
        5'd24: begin
          word = goTo(UA_FETCH);
          word.ctl.accOe = 1'b1;
          word.ctl.memWe = 1'b1;
        end
        5'd26: begin
          word.seq    = SEQ_IFZERO;
          word.target = UA_JZ_TAKEN;
        end
        5'd27: word = goTo(UA_FETCH);
        5'd28: begin
          word = goTo(UA_FETCH);
          word.ctl.memOe = 1'b1;
          word.ctl.pcLd  = 1'b1;
        end
        5'd30: begin
          word = goTo(UA_FETCH);
          word.ctl.constOe = 1'b1;
          word.ctl.accLd   = 1'b1;
        end
        5'd31: begin
          word = goTo(UA_FETCH);
          word.ctl.stop = 1'b1;
        end
        default: word = '0;
      endcase
    end
  end

endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] busOp,
  input  logic            accZero,
  output strobe_t         strb,
  output logic [UA_W-1:0] uAddr,
  output logic            halted
);

  logic [UA_W-1:0] uPc;
  logic [UA_W-1:0] uNext;
  uword_t          word;
  logic            stopNow;

  mc_urom u_rom (
    .addr (uPc),
    .word (word)
  );

  assign stopNow = halted | word.ctl.stop;

  always_comb begin
    unique case (word.seq)
      SEQ_JUMP:   uNext = word.fromBus ? UA_W'(busOp) : word.target;
      SEQ_IFZERO: uNext = accZero ? word.target : uPc + 1'b1;
      default:    uNext = uPc + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uPc    <= '0;
      halted <= 1'b0;
    end else begin
      if (!stopNow) uPc <= uNext;
      if (word.ctl.stop) halted <= 1'b1;
    end
  end

  assign strb  = halted ? '0 : word.ctl;
  assign uAddr = uPc;

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [OP_W-1:0]   busOp,
  output logic              accZero
);

  localparam int DEPTH = 1 << DATA_W;
  localparam int NSRC  = 4;

  logic [DATA_W-1:0] pcR, marR, abrR, accR;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memRd, bus, aluOut;
  logic [DATA_W-1:0] srcVal   [NSRC];
  logic [DATA_W-1:0] gatedVal [NSRC];
  logic [NSRC-1:0]   srcEn;
  logic              live;

  assign memRd = mem[marR];

  assign srcVal[0] = pcR;
  assign srcVal[1] = '0;
  assign srcVal[2] = accR;
  assign srcVal[3] = memRd;
  assign srcEn     = {strb.memOe, strb.accOe, strb.constOe, strb.pcOe};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign gatedVal[g] = srcEn[g] ? srcVal[g] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gatedVal[i];
  end

  assign aluOut = strb.aluSub ? abrR - bus : abrR + bus;
  assign live   = !strb.stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcR  <= '0;
      marR <= '0;
      abrR <= '0;
      accR <= '0;
    end else if (live) begin
      if (strb.pcLd)       pcR <= bus;
      else if (strb.pcInc) pcR <= pcR + 1'b1;
      if (strb.marLd) marR <= bus;
      if (strb.abrLd) abrR <= bus;
      if (strb.accLd) accR <= aluOut;
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn)                  mem[loadAddr] <= loadData;
    else if (live && strb.memWe) mem[marR]     <= bus;
  end

  assign peekData = mem[peekAddr];
  assign pcOut    = pcR;
  assign accOut   = accR;
  assign busOp    = bus[OP_W-1:0];
  assign accZero  = (accR == '0);

endmodule

// File: rtl/mc_accum_cpu.sv
module mc_accum_cpu
  import mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [UA_W-1:0]   uAddr,
  output logic              halted
);

  strobe_t         strb;
  logic [OP_W-1:0] busOp;
  logic            accZero;

  mc_control u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busOp   (busOp),
    .accZero (accZero),
    .strb    (strb),
    .uAddr   (uAddr),
    .halted  (halted)
  );

  mc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .peekAddr (peekAddr),
    .peekData (peekData),
    .pcOut    (pcOut),
    .accOut   (accOut),
    .busOp    (busOp),
    .accZero  (accZero)
  );

endmodule

// File: rtl/mc_checker.sv
module mc_checker
  import mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        busDrivers,
  input logic [UA_W-1:0]   uAddr,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              halted
);

  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd0 && !halted) |=> (uAddr == 5'd8));

  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busDrivers) <= 1);

  p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd8 && !halted) |=> (uAddr == 5'd9));

  p_dispatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd9) |=> (uAddr < 5'd8));

  p_load_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd13) |=> (uAddr == 5'd8));

  p_jz_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd26 && acc == '0) |=> (uAddr == 5'd28));

  p_jz_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd26 && acc != '0) |=> (uAddr == 5'd27));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd30) |=> (acc == '0));

  p_halt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uAddr == 5'd31) |=> halted);

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && uAddr == 5'd31 && $stable(pc) && $stable(acc)));

endmodule

bind mc_accum_cpu mc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busDrivers ({strb.pcOe, strb.constOe, strb.accOe, strb.memOe}),
  .uAddr      (uAddr),
  .pc         (pcOut),
  .acc        (accOut),
  .halted     (halted)
);

// File: tb/sim_mc_accum_cpu.sv
module sim_mc_accum_cpu;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 8;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadEn = 1'b0;
  logic [DW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic [DW-1:0] peekAddr = '0;
  logic [DW-1:0] peekData, pcOut, accOut;
  logic [4:0]    uAddr;
  logic          halted;

  mc_accum_cpu #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .peekAddr(peekAddr), .peekData(peekData),
    .pcOut(pcOut), .accOut(accOut), .uAddr(uAddr), .halted(halted)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] refMem [DEPTH];
  int    rpc, racc;
  bit    refHalt;
  int    expQ[$];
  string curTag, prevTag;
  int    haltCycles;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural instruction-level model; pushes the expected microaddress trail
  task automatic execInstr();
    int op, opnd;
    op = refMem[rpc] & 7;
    rpc = (rpc + 1) % 256;
    opnd = 0;
    if (op >= 1 && op <= 5) begin
      opnd = refMem[rpc];
      rpc = (rpc + 1) % 256;
    end
    expQ.push_back(9);
    expQ.push_back(op);
    case (op)
      0: begin curTag = "R10"; expQ.push_back(8); end
      1: begin
        curTag = "R3";
        expQ.push_back(10); expQ.push_back(11); expQ.push_back(12);
        expQ.push_back(13); expQ.push_back(8);
        racc = refMem[opnd];
      end
      2: begin
        curTag = "R4";
        expQ.push_back(14); expQ.push_back(15); expQ.push_back(16);
        expQ.push_back(17); expQ.push_back(8);
        racc = (racc + refMem[opnd]) & 255;
      end
      3: begin
        curTag = "R5";
        expQ.push_back(18); expQ.push_back(19); expQ.push_back(20);
        expQ.push_back(21); expQ.push_back(8);
        racc = (racc - refMem[opnd]) & 255;
      end
      4: begin
        curTag = "R6";
        expQ.push_back(22); expQ.push_back(23); expQ.push_back(24);
        expQ.push_back(8);
        refMem[opnd] = 8'(racc);
      end
      5: begin
        curTag = "R7";
        expQ.push_back(25); expQ.push_back(26);
        if (racc == 0) begin
          expQ.push_back(28);
          rpc = opnd;
        end else begin
          expQ.push_back(27);
        end
        expQ.push_back(8);
      end
      6: begin
        curTag = "R8";
        expQ.push_back(29); expQ.push_back(30); expQ.push_back(8);
        racc = 0;
      end
      default: begin
        curTag = "R9";
        expQ.push_back(31);
        refHalt = 1;
      end
    endcase
  endtask

  task automatic step();
    int e;
    if (expQ.size() == 0) begin
      // halted phase (R9)
      chk(int'(uAddr) == 31, "R9", "uAddr held", int'(uAddr), 31);
      chk(halted == 1'b1, "R9", "halted", int'(halted), 1);
      chk(int'(pcOut) == rpc, "R9", "pc frozen", int'(pcOut), rpc);
      chk(int'(accOut) == racc, "R9", "acc frozen", int'(accOut), racc);
      haltCycles++;
    end else begin
      e = expQ.pop_front();
      chk(int'(uAddr) == e, (e == 8 || e == 9) ? "R2" : curTag, "uAddr",
          int'(uAddr), e);
      if (e == 8) begin
        chk(int'(pcOut) == rpc, prevTag, "pc at fetch", int'(pcOut), rpc);
        chk(int'(accOut) == racc, prevTag, "acc at fetch", int'(accOut), racc);
        chk(halted == 1'b0, "R9", "not halted while running", int'(halted), 0);
        execInstr();
        prevTag = curTag;
      end
    end
  endtask

  task automatic runProgram();
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      loadEn = 1'b1;
      loadAddr = DW'(i);
      loadData = refMem[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    // R1 reset state
    chk(uAddr == 5'd0, "R1", "uAddr in reset", int'(uAddr), 0);
    chk(pcOut == 8'd0, "R1", "pc in reset", int'(pcOut), 0);
    chk(accOut == 8'd0, "R1", "acc in reset", int'(accOut), 0);
    chk(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    rpc = 0; racc = 0; refHalt = 0; haltCycles = 0;
    expQ.delete();
    expQ.push_back(8);
    prevTag = "R1"; curTag = "R1";
    rst_n = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      step();
      if (haltCycles >= 8) break;
    end
    chk(haltCycles >= 8, "R9", "program reached halt", haltCycles, 8);
    // memory read-back against model (R6, R9)
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        peekAddr = DW'(i);
        #0.5;
        if (peekData !== refMem[i]) begin
          if (bad == 0)
            chk(1'b0, "R6", $sformatf("mem[%0h]", i), int'(peekData), int'(refMem[i]));
          bad++;
        end
      end
      if (bad == 0) chk(1'b1, "R6", "memory image", 0, 0);
    end
  endtask

  task automatic peekChk(input int a, input int exp, input string req);
    peekAddr = DW'(a);
    #0.5;
    chk(int'(peekData) == exp, req, $sformatf("mem[%0h]", a), int'(peekData), exp);
  endtask

  initial begin
    // program 1: every opcode, wrap-around, masked opcode bits, both jump outcomes
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    refMem[8'h00] = 8'h01; refMem[8'h01] = 8'h80;   // R3 load 0xF0
    refMem[8'h02] = 8'h02; refMem[8'h03] = 8'h81;   // R4 +0x20 wraps to 0x10
    refMem[8'h04] = 8'h03; refMem[8'h05] = 8'h82;   // R5 -0x30 wraps to 0xE0
    refMem[8'h06] = 8'h04; refMem[8'h07] = 8'h90;   // R6 store
    refMem[8'h08] = 8'h05; refMem[8'h09] = 8'h40;   // R7 not taken
    refMem[8'h0A] = 8'h00;                          // R10 no-op
    refMem[8'h0B] = 8'h06;                          // R8 clear
    refMem[8'h0C] = 8'h0D; refMem[8'h0D] = 8'h20;   // R2/R7 masked jump, taken
    refMem[8'h0E] = 8'h07;                          // skipped halt
    refMem[8'h20] = 8'h0A; refMem[8'h21] = 8'h83;   // R2 masked add 5
    refMem[8'h22] = 8'h04; refMem[8'h23] = 8'h91;
    refMem[8'h24] = 8'h07;                          // R9 halt
    refMem[8'h80] = 8'hF0; refMem[8'h81] = 8'h20;
    refMem[8'h82] = 8'h30; refMem[8'h83] = 8'h05;
    runProgram();
    peekChk(8'h90, 8'hE0, "R6");
    peekChk(8'h91, 8'h05, "R6");
    chk(accOut == 8'h05, "R4", "final acc", int'(accOut), 5);
    chk(pcOut == 8'h25, "R9", "final pc", int'(pcOut), 8'h25);

    // program 2: countdown loop driven by the zero branch
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    refMem[8'h02] = 8'h01; refMem[8'h03] = 8'h82;   // load count
    refMem[8'h04] = 8'h03; refMem[8'h05] = 8'h81;   // minus one
    refMem[8'h06] = 8'h04; refMem[8'h07] = 8'h82;   // store count
    refMem[8'h08] = 8'h05; refMem[8'h09] = 8'h10;   // exit when zero
    refMem[8'h0A] = 8'h06;                          // clear
    refMem[8'h0B] = 8'h05; refMem[8'h0C] = 8'h02;   // back to top
    refMem[8'h10] = 8'h07;
    refMem[8'h81] = 8'h01; refMem[8'h82] = 8'h03;
    runProgram();
    peekChk(8'h82, 8'h00, "R7");
    chk(accOut == 8'h00, "R7", "loop acc", int'(accOut), 0);
    chk(pcOut == 8'h11, "R9", "loop pc", int'(pcOut), 8'h11);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

endmodule